// File: doc/BRIEF.md
# Striding Receive Completion Handler

This block sits behind the completion queue of a receive ring in which each posted buffer is carved into many equal strides and carries several packets. It takes one completion record per cycle and sorts it into one of three kinds: a normal receive, a filler record that only consumes strides, or an error. For a normal receive it turns the stride index and byte count into a packet descriptor. The descriptor gives the packet's byte offset in its buffer, the span to make visible to the host, a linear header length capped at 128 bytes, and at most one payload fragment holding the rest of the packet.

Each buffer has a running count of consumed strides, indexed by buffer ID. Every accepted completion adds to it, whatever its kind. When the count reaches the strides-per-buffer value, the block pulses a release strobe with that buffer's ID to the refill logic. A repost input clears a buffer's count once the refill logic has handed the buffer back to the device. Four running counters record good packets, good bytes, filler records and error records.

Top module: `stride_cq_handler`

## Requirements
- R1: `cq_ready` is low in any cycle in which `post_valid` is high and high otherwise. A completion is accepted only when `cq_valid` and `cq_ready` are both high.
- R2: Every accepted completion adds its stride count (bits 14:0 of `cq_fill_strides`) to its buffer's running count, whether the completion is good, filler or error. When that sum reaches 1024 or more, `rel_valid` pulses for one cycle with `rel_buf_id` equal to the buffer.
- R3: A repost (`post_valid` with `post_buf_id`) sets that buffer's running count to zero, so later completions for it count from zero.
- R4: An accepted completion whose `cq_opcode` is not 4'h2 increments `cnt_err` by one and produces no packet descriptor.
- R5: An accepted completion with opcode 4'h2 and bit 15 of `cq_fill_strides` set is a filler. It increments `cnt_filler` by one and produces no packet descriptor.
- R6: For a good completion, `pkt_offset` = stride index × 128 and `pkt_span` = stride count × 128. `pkt_buf_id` is the completion's buffer ID.
- R7: `pkt_hdr_len` = min(128, byte count). When the byte count exceeds 128, `pkt_frag_valid` is high, `pkt_frag_offset` = `pkt_offset` + header length and `pkt_frag_len` = byte count − header length. Otherwise `pkt_frag_valid` is low.
- R8: A good completion (opcode 4'h2, bit 15 clear) raises `pkt_valid`, increments `cnt_pkts` by one and adds its byte count to `cnt_bytes`. `pkt_byte_cnt` carries that byte count.
- R9: The descriptor, the release strobe and the counter updates appear on the clock edge that accepts the completion, so they are visible one cycle after it was presented. `pkt_valid` and `rel_valid` are low after any cycle with no accepted completion.
- R10: After reset, all counters, all running counts, `pkt_valid` and `rel_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cq_valid | input | 1 | Completion record present |
| cq_ready | output | 1 | Completion can be accepted this cycle |
| cq_opcode | input | 4 | Completion opcode; 4'h2 is a normal receive |
| cq_buf_id | input | 4 | Buffer the completion refers to |
| cq_stride_idx | input | 10 | First stride of the packet |
| cq_fill_strides | input | 16 | Bit 15 filler flag, bits 14:0 strides consumed |
| cq_byte_cnt | input | 16 | Packet length in bytes |
| post_valid | input | 1 | Buffer reposted this cycle |
| post_buf_id | input | 4 | Buffer being reposted |
| pkt_valid | output | 1 | Packet descriptor valid |
| pkt_buf_id | output | 4 | Buffer holding the packet |
| pkt_offset | output | 18 | Byte offset of the packet in the buffer |
| pkt_span | output | 22 | Bytes covered by the consumed strides |
| pkt_hdr_len | output | 8 | Linear header length |
| pkt_frag_valid | output | 1 | Payload fragment present |
| pkt_frag_offset | output | 18 | Fragment byte offset in the buffer |
| pkt_frag_len | output | 16 | Fragment length in bytes |
| pkt_byte_cnt | output | 16 | Total packet length |
| rel_valid | output | 1 | Buffer fully consumed, release it |
| rel_buf_id | output | 4 | Buffer being released |
| cnt_pkts | output | 32 | Good packet count |
| cnt_bytes | output | 32 | Good byte count |
| cnt_filler | output | 32 | Filler completion count |
| cnt_err | output | 32 | Error completion count |

## Verification
A running count that is corrupted, skipped for a filler or error record, or left uncleared after a repost cannot be seen until that buffer's last completion arrives. At that point the release strobe comes early, late or never, so the bench walks buffers right up to the 1024-stride limit, across it, and across reposts, and compares the strobe in every cycle. A wrong classification shows at the next edge as a spurious or missing descriptor and as a counter that has drifted by one. A wrong split shows in the offset, header and fragment fields of that same descriptor, which the bench checks at the 128-byte boundary and at the last stride index.

// File: rtl/strq_pkg.sv
package strq_pkg;

    localparam int LOG_STRIDES      = 10;
    localparam int LOG_STRIDE_BYTES = 7;
    localparam int STRIDES_PER_BUF  = 1 << LOG_STRIDES;
    localparam int OP_W             = 4;
    localparam int BID_W            = 4;
    localparam int IDX_W            = LOG_STRIDES;
    localparam int SCNT_W           = 15;
    localparam int WORD_W           = SCNT_W + 1;
    localparam int BCNT_W           = 16;
    localparam int OFF_W            = LOG_STRIDES + LOG_STRIDE_BYTES + 1;
    localparam int SPAN_W           = SCNT_W + LOG_STRIDE_BYTES;
    localparam int LED_W            = LOG_STRIDES + 1;
    localparam int HDR_CAP          = 128;
    localparam int HLEN_W           = 8;

    typedef enum logic [1:0] {
        CQ_GOOD   = 2'd0,
        CQ_FILLER = 2'd1,
        CQ_ERROR  = 2'd2
    } cq_kind_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [BID_W-1:0]  bid;
        logic [IDX_W-1:0]  idx;
        logic              filler;
        logic [SCNT_W-1:0] strides;
        logic [BCNT_W-1:0] bcnt;
    } cqe_t;

    typedef struct packed {
        logic [BID_W-1:0]  bid;
        logic [OFF_W-1:0]  off;
        logic [SPAN_W-1:0] span;
        logic [HLEN_W-1:0] hdr_len;
        logic              frag_vld;
        logic [OFF_W-1:0]  frag_off;
        logic [BCNT_W-1:0] frag_len;
        logic [BCNT_W-1:0] bcnt;
    } pkt_desc_t;

    function automatic cq_kind_e classify(input logic [OP_W-1:0] op,
                                          input logic filler,
                                          input logic [OP_W-1:0] good_op);
        if (op != good_op)
            return CQ_ERROR;
        else if (filler)
            return CQ_FILLER;
        else
            return CQ_GOOD;
    endfunction

endpackage

// File: rtl/cqe_splitter.sv
module cqe_splitter
    import strq_pkg::*;
#(
    parameter logic [OP_W-1:0] GOOD_OP = 4'h2
) (
    input  cqe_t      cqe,
    output cq_kind_e  kind,
    output pkt_desc_t desc
);

    logic [HLEN_W-1:0] hlen;
    logic [OFF_W-1:0]  base;

    always_comb begin
        kind = classify(cqe.op, cqe.filler, GOOD_OP);
        base = OFF_W'({cqe.idx, LOG_STRIDE_BYTES'(0)});
        if (cqe.bcnt >= BCNT_W'(HDR_CAP))
            hlen = HLEN_W'(HDR_CAP);
        else
            hlen = cqe.bcnt[HLEN_W-1:0];

        desc.bid      = cqe.bid;
        desc.off      = base;
        desc.span     = SPAN_W'({cqe.strides, LOG_STRIDE_BYTES'(0)});
        desc.hdr_len  = hlen;
        desc.frag_vld = cqe.bcnt > BCNT_W'(HDR_CAP);
        desc.frag_off = base + OFF_W'(hlen);
        desc.frag_len = cqe.bcnt - BCNT_W'(hlen);
        desc.bcnt     = cqe.bcnt;
    end

endmodule

// File: rtl/stride_ledger.sv
module stride_ledger
    import strq_pkg::*;
#(
    parameter int NUM_BUFS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_vld,
    input  logic [BID_W-1:0]  post_bid,
    input  logic              acc_vld,
    input  logic [BID_W-1:0]  acc_bid,
    input  logic [SCNT_W-1:0] acc_strides,
    output logic              rel_vld,
    output logic [BID_W-1:0]  rel_bid
);

    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(STRIDES_PER_BUF);

    logic [LED_W-1:0]  tally [NUM_BUFS];
    logic [LED_W-1:0]  cur;
    logic              hit;
    logic [WORD_W-1:0] sum;
    logic              full;
    logic [LED_W-1:0]  nxt;

    always_comb begin
        cur = '0;
        hit = 1'b0;
        for (int i = 0; i < NUM_BUFS; i++) begin
            if (acc_bid == BID_W'(i)) begin
                cur = tally[i];
                hit = 1'b1;
            end
        end
        sum  = WORD_W'(cur) + WORD_W'(acc_strides);
        full = sum >= LIMIT;
        nxt  = full ? LED_W'(STRIDES_PER_BUF) : sum[LED_W-1:0];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BUFS; i++) begin
            if (rst)
                tally[i] <= '0;
            else if (post_vld && post_bid == BID_W'(i))
                tally[i] <= '0;
            else if (acc_vld && acc_bid == BID_W'(i))
                tally[i] <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_vld <= 1'b0;
            rel_bid <= '0;
        end else begin
            rel_vld <= acc_vld && hit && full;
            rel_bid <= acc_bid;
        end
    end

endmodule

// File: rtl/cq_stat_counters.sv
module cq_stat_counters
    import strq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_pkt,
    input  logic              inc_fill,
    input  logic              inc_err,
    input  logic [BCNT_W-1:0] add_bytes,
    output logic [CNT_W-1:0]  cnt_pkts,
    output logic [CNT_W-1:0]  cnt_bytes,
    output logic [CNT_W-1:0]  cnt_filler,
    output logic [CNT_W-1:0]  cnt_err
);

    localparam int NEV = 3;

    logic [NEV-1:0]   ev;
    logic [CNT_W-1:0] tallies [NEV];

    assign ev = {inc_err, inc_fill, inc_pkt};

    generate
        for (genvar g = 0; g < NEV; g++) begin : g_evc
            always_ff @(posedge clk) begin
                if (rst)
                    tallies[g] <= '0;
                else if (ev[g])
                    tallies[g] <= tallies[g] + CNT_W'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt_bytes <= '0;
        else if (inc_pkt)
            cnt_bytes <= cnt_bytes + CNT_W'(add_bytes);
    end

    assign cnt_pkts   = tallies[0];
    assign cnt_filler = tallies[1];
    assign cnt_err    = tallies[2];

endmodule

// File: rtl/stride_cq_handler.sv
module stride_cq_handler
    import strq_pkg::*;
#(
    parameter int               NUM_BUFS = 16,
    parameter int               CNT_W    = 32,
    parameter logic [OP_W-1:0]  GOOD_OP  = 4'h2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cq_valid,
    output logic              cq_ready,
    input  logic [OP_W-1:0]   cq_opcode,
    input  logic [BID_W-1:0]  cq_buf_id,
    input  logic [IDX_W-1:0]  cq_stride_idx,
    input  logic [WORD_W-1:0] cq_fill_strides,
    input  logic [BCNT_W-1:0] cq_byte_cnt,
    input  logic              post_valid,
    input  logic [BID_W-1:0]  post_buf_id,
    output logic              pkt_valid,
    output logic [BID_W-1:0]  pkt_buf_id,
    output logic [OFF_W-1:0]  pkt_offset,
    output logic [SPAN_W-1:0] pkt_span,
    output logic [HLEN_W-1:0] pkt_hdr_len,
    output logic              pkt_frag_valid,
    output logic [OFF_W-1:0]  pkt_frag_offset,
    output logic [BCNT_W-1:0] pkt_frag_len,
    output logic [BCNT_W-1:0] pkt_byte_cnt,
    output logic              rel_valid,
    output logic [BID_W-1:0]  rel_buf_id,
    output logic [CNT_W-1:0]  cnt_pkts,
    output logic [CNT_W-1:0]  cnt_bytes,
    output logic [CNT_W-1:0]  cnt_filler,
    output logic [CNT_W-1:0]  cnt_err
);

    cqe_t      rec;
    cq_kind_e  kind;
    pkt_desc_t desc_d;
    pkt_desc_t desc_q;
    logic      take;
    logic      is_good;

    // The repost owns the tally write port in its cycle.
    assign cq_ready = !post_valid;
    assign take     = cq_valid && cq_ready;

    always_comb begin
        rec.op      = cq_opcode;
        rec.bid     = cq_buf_id;
        rec.idx     = cq_stride_idx;
        rec.filler  = cq_fill_strides[WORD_W-1];
        rec.strides = cq_fill_strides[SCNT_W-1:0];
        rec.bcnt    = cq_byte_cnt;
    end

    cqe_splitter #(.GOOD_OP(GOOD_OP)) u_split (
        .cqe  (rec),
        .kind (kind),
        .desc (desc_d)
    );

    assign is_good = take && (kind == CQ_GOOD);

    stride_ledger #(.NUM_BUFS(NUM_BUFS)) u_ledger (
        .clk         (clk),
        .rst         (rst),
        .post_vld    (post_valid),
        .post_bid    (post_buf_id),
        .acc_vld     (take),
        .acc_bid     (rec.bid),
        .acc_strides (rec.strides),
        .rel_vld     (rel_valid),
        .rel_bid     (rel_buf_id)
    );

    cq_stat_counters #(.CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst        (rst),
        .inc_pkt    (is_good),
        .inc_fill   (take && (kind == CQ_FILLER)),
        .inc_err    (take && (kind == CQ_ERROR)),
        .add_bytes  (rec.bcnt),
        .cnt_pkts   (cnt_pkts),
        .cnt_bytes  (cnt_bytes),
        .cnt_filler (cnt_filler),
        .cnt_err    (cnt_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid <= 1'b0;
            desc_q    <= '0;
        end else begin
            pkt_valid <= is_good;
            if (is_good)
                desc_q <= desc_d;
        end
    end

    assign pkt_buf_id      = desc_q.bid;
    assign pkt_offset      = desc_q.off;
    assign pkt_span        = desc_q.span;
    assign pkt_hdr_len     = desc_q.hdr_len;
    assign pkt_frag_valid  = desc_q.frag_vld;
    assign pkt_frag_offset = desc_q.frag_off;
    assign pkt_frag_len    = desc_q.frag_len;
    assign pkt_byte_cnt    = desc_q.bcnt;

endmodule

// File: rtl/stride_cq_checker.sv
module stride_cq_checker
    import strq_pkg::*;
#(
    parameter int               CNT_W   = 32,
    parameter logic [OP_W-1:0]  GOOD_OP = 4'h2
) (
    input logic              clk,
    input logic              rst,
    input logic              cq_valid,
    input logic              cq_ready,
    input logic [OP_W-1:0]   cq_opcode,
    input logic [WORD_W-1:0] cq_fill_strides,
    input logic [BCNT_W-1:0] cq_byte_cnt,
    input logic              pkt_valid,
    input logic [HLEN_W-1:0] pkt_hdr_len,
    input logic              pkt_frag_valid,
    input logic [BCNT_W-1:0] pkt_frag_len,
    input logic [BCNT_W-1:0] pkt_byte_cnt,
    input logic              rel_valid,
    input logic [CNT_W-1:0]  cnt_bytes,
    input logic [CNT_W-1:0]  cnt_filler,
    input logic [CNT_W-1:0]  cnt_err
);

    logic acc;
    assign acc = cq_valid && cq_ready;

    a_r4_err_counted: assert property (@(posedge clk) disable iff (rst)
        (acc && cq_opcode != GOOD_OP) |=>
            (!pkt_valid && cnt_err == $past(cnt_err) + CNT_W'(1)));

    a_r5_filler_counted: assert property (@(posedge clk) disable iff (rst)
        (acc && cq_opcode == GOOD_OP && cq_fill_strides[WORD_W-1]) |=>
            (!pkt_valid && cnt_filler == $past(cnt_filler) + CNT_W'(1)));

    a_r8_bytes_added: assert property (@(posedge clk) disable iff (rst)
        (acc && cq_opcode == GOOD_OP && !cq_fill_strides[WORD_W-1]) |=>
            (pkt_valid && cnt_bytes == $past(cnt_bytes) + CNT_W'($past(cq_byte_cnt))));

    a_r7_split_sums: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (BCNT_W'(pkt_hdr_len) + pkt_frag_len == pkt_byte_cnt));

    a_r7_frag_flag: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_frag_valid == (pkt_frag_len != '0)));

    a_r9_release_source: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> $past(acc));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (!pkt_valid && !rel_valid));

endmodule

bind stride_cq_handler stride_cq_checker #(.CNT_W(CNT_W), .GOOD_OP(GOOD_OP)) u_chk (.*);

// File: tb/sim_stride_cq_handler.sv
module sim_stride_cq_handler;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] GOOD = 4'h2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cq_valid = 1'b0;
    logic        cq_ready;
    logic [3:0]  cq_opcode = '0;
    logic [3:0]  cq_buf_id = '0;
    logic [9:0]  cq_stride_idx = '0;
    logic [15:0] cq_fill_strides = '0;
    logic [15:0] cq_byte_cnt = '0;
    logic        post_valid = 1'b0;
    logic [3:0]  post_buf_id = '0;
    logic        pkt_valid;
    logic [3:0]  pkt_buf_id;
    logic [17:0] pkt_offset;
    logic [21:0] pkt_span;
    logic [7:0]  pkt_hdr_len;
    logic        pkt_frag_valid;
    logic [17:0] pkt_frag_offset;
    logic [15:0] pkt_frag_len;
    logic [15:0] pkt_byte_cnt;
    logic        rel_valid;
    logic [3:0]  rel_buf_id;
    logic [31:0] cnt_pkts, cnt_bytes, cnt_filler, cnt_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_cq_handler u0 (.*);

    int errs = 0;
    int checks = 0;

    // reference state
    int          led [16];
    bit [31:0]   m_pkts = 0, m_bytes = 0, m_fill = 0, m_err = 0;
    bit          e_pkt, e_rel, e_frag;
    int          e_bid, e_relbid, e_off, e_span, e_hdr, e_foff, e_flen, e_bc;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic compare();
        chk(pkt_valid == e_pkt, "R9", "pkt_valid", pkt_valid, e_pkt);
        if (e_pkt && pkt_valid) begin
            chk(pkt_buf_id == e_bid, "R6", "pkt_buf_id", pkt_buf_id, e_bid);
            chk(pkt_offset == e_off, "R6", "pkt_offset", pkt_offset, e_off);
            chk(pkt_span == e_span, "R6", "pkt_span", pkt_span, e_span);
            chk(pkt_hdr_len == e_hdr, "R7", "pkt_hdr_len", pkt_hdr_len, e_hdr);
            chk(pkt_frag_valid == e_frag, "R7", "pkt_frag_valid", pkt_frag_valid, e_frag);
            if (e_frag) begin
                chk(pkt_frag_offset == e_foff, "R7", "pkt_frag_offset", pkt_frag_offset, e_foff);
                chk(pkt_frag_len == e_flen, "R7", "pkt_frag_len", pkt_frag_len, e_flen);
            end
            chk(pkt_byte_cnt == e_bc, "R8", "pkt_byte_cnt", pkt_byte_cnt, e_bc);
        end
        chk(rel_valid == e_rel, "R2", "rel_valid", rel_valid, e_rel);
        if (e_rel && rel_valid)
            chk(rel_buf_id == e_relbid, "R2", "rel_buf_id", rel_buf_id, e_relbid);
        chk(cnt_pkts == m_pkts, "R8", "cnt_pkts", cnt_pkts, m_pkts);
        chk(cnt_bytes == m_bytes, "R8", "cnt_bytes", cnt_bytes, m_bytes);
        chk(cnt_filler == m_fill, "R5", "cnt_filler", cnt_filler, m_fill);
        chk(cnt_err == m_err, "R4", "cnt_err", cnt_err, m_err);
    endtask

    // drive one cycle of inputs (called at a falling edge), predict, then compare
    task automatic apply(input bit pv, input logic [3:0] pid, input bit v,
                         input logic [3:0] op, input logic [3:0] bid,
                         input logic [9:0] idx, input logic [15:0] fs,
                         input logic [15:0] bc);
        bit acc;
        int s;
        post_valid = pv; post_buf_id = pid; cq_valid = v; cq_opcode = op;
        cq_buf_id = bid; cq_stride_idx = idx; cq_fill_strides = fs; cq_byte_cnt = bc;
        #1;
        chk(cq_ready == !pv, "R1", "cq_ready", cq_ready, !pv);
        acc = v && !pv;
        e_pkt = 0; e_rel = 0;
        if (pv) led[pid] = 0;
        if (acc) begin
            s = led[bid] + int'(fs[14:0]);
            if (s >= 1024) begin
                e_rel = 1; e_relbid = bid; led[bid] = 1024;
            end else begin
                led[bid] = s;
            end
            if (op != GOOD) m_err++;
            else if (fs[15]) m_fill++;
            else begin
                e_pkt  = 1;
                e_bid  = bid;
                e_off  = int'(idx) * 128;
                e_span = int'(fs[14:0]) * 128;
                e_hdr  = (bc >= 128) ? 128 : int'(bc);
                e_frag = bc > 128;
                e_foff = e_off + e_hdr;
                e_flen = int'(bc) - e_hdr;
                e_bc   = bc;
                m_pkts++;
                m_bytes += 32'(bc);
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic cq(input logic [3:0] op, input logic [3:0] bid,
                      input logic [9:0] idx, input logic [15:0] fs,
                      input logic [15:0] bc);
        apply(1'b0, 4'd0, 1'b1, op, bid, idx, fs, bc);
    endtask

    task automatic idle();
        apply(1'b0, 4'd0, 1'b0, 4'd0, 4'd0, 10'd0, 16'd0, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) led[i] = 0;
        e_pkt = 0; e_rel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(pkt_valid == 0, "R10", "pkt_valid after reset", pkt_valid, 0);
        chk(rel_valid == 0, "R10", "rel_valid after reset", rel_valid, 0);
        chk(cnt_pkts == 0 && cnt_bytes == 0, "R10", "good counters", cnt_pkts + cnt_bytes, 0);
        chk(cnt_filler == 0 && cnt_err == 0, "R10", "other counters", cnt_filler + cnt_err, 0);
        idle();

        // R6 R7 short packet, exact-cap packet, one past the cap, large packet
        cq(GOOD, 4'd0, 10'd0, 16'd1, 16'd64);
        cq(GOOD, 4'd0, 10'd1, 16'd1, 16'd128);
        cq(GOOD, 4'd0, 10'd2, 16'd2, 16'd129);
        cq(GOOD, 4'd0, 10'd5, 16'd12, 16'd1500);
        idle();
        // R4 error, strides still counted (R2)
        cq(4'hd, 4'd1, 10'd0, 16'd3, 16'd60);
        // R5 filler
        cq(GOOD, 4'd1, 10'd3, 16'h8000 | 16'd20, 16'd0);
        cq(4'h0, 4'd1, 10'd0, 16'h8000 | 16'd1, 16'd0);
        // R2 reach the limit exactly on buffer 2
        cq(GOOD, 4'd2, 10'd0, 16'd1000, 16'd9000);
        cq(GOOD, 4'd2, 10'd1000, 16'd24, 16'd3000);
        // R2 overshoot on buffer 3, last stride index (R7 frag offset 131072)
        cq(GOOD, 4'd3, 10'd0, 16'd1023, 16'd7000);
        cq(GOOD, 4'd3, 10'd1023, 16'd5, 16'd300);
        // R1 repost blocks the completion; R3 count restarts from zero
        apply(1'b1, 4'd3, 1'b1, GOOD, 4'd3, 10'd0, 16'd1000, 16'd64);
        cq(GOOD, 4'd3, 10'd0, 16'd1000, 16'd64);
        cq(GOOD, 4'd3, 10'd1000, 16'd23, 16'd64);
        cq(4'h7, 4'd3, 10'd0, 16'd1, 16'd64);
        // R3 buffer 2 reposted, one whole-buffer filler releases at once
        apply(1'b1, 4'd2, 1'b0, GOOD, 4'd0, 10'd0, 16'd0, 16'd0);
        cq(GOOD, 4'd2, 10'd0, 16'h8000 | 16'd1024, 16'd0);
        idle();

        // mixed traffic
        void'($urandom(7));
        for (int n = 0; n < 400; n++) begin
            bit pv = ($urandom_range(0, 9) == 0);
            logic [3:0] op = ($urandom_range(0, 7) == 0) ? 4'(($urandom_range(0, 15))) : GOOD;
            logic [15:0] fs = 16'($urandom_range(0, 300));
            if ($urandom_range(0, 6) == 0) fs[15] = 1'b1;
            apply(pv, 4'($urandom_range(0, 15)), $urandom_range(0, 4) != 0, op,
                  4'($urandom_range(0, 15)), 10'($urandom_range(0, 1023)), fs,
                  16'($urandom_range(0, 400)));
        end
        idle();
        summary();
        $finish;
    end

endmodule